// File: doc/BRIEF.md
# Audio Delay-Line DRAM Controller

This block sits between the effects datapath and an external 64K x 4 dynamic RAM that holds audio delay lines. The datapath raises a request made of a 16-bit word address, a read/write flag and, for writes, a 4-bit value. The controller turns each request into a row/column access on a 9-line multiplexed address bus, with active-low row and column strobes, separate active-low read and write strobes, and a 4-bit bidirectional data bus. Read results come back as one nibble with a single-cycle valid pulse.

A row stays open while the datapath keeps asking for words in the same row. Each extra word then costs only a column cycle of fixed length. A change of row, an idle gap, or reaching the per-row access limit closes the row and precharges it. All spacings are whole clock counts. The defaults are the minimum datasheet times rounded up at a 768fs master clock of about 29.5 ns. Refresh is left to the access pattern of the delay lines.

Top module: `dline_dram_ctrl`

## Requirements
- R1: While reset is held and after it is released, with no request: ras_n_o, cas_n_o, rd_n_o and we_n_o are high, busy_o and rd_valid_o are low, and the data bus is not driven.
- R2: ras_n_o stays high for at least 3 cycles before every falling edge.
- R3: The row (address bits 15:8) is on dram_a_o when ras_n_o falls and stays there for 1 cycle. The column (bits 7:0) follows, with dram_a_o[8] zero in both phases. cas_n_o falls 3 cycles after ras_n_o falls, with the column already stable on the bus.
- R4: cas_n_o stays low for exactly 4 cycles. Between two column accesses in one open row it stays high for exactly 2 cycles, so one column cycle is 6 cycles.
- R5: For a write, we_n_o is low exactly while cas_n_o is low and rd_n_o stays high. The write nibble is on the bus for the 2 cycles before we_n_o falls and for the whole time it is low.
- R6: For a read, rd_n_o is low exactly while cas_n_o is low. The bus is sampled at the clock edge where cas_n_o rises. rd_valid_o is high for one cycle after that edge, with the nibble on rd_data_o.
- R7: The controller drives the data bus only during the column phase of a write. It never drives the bus while rd_n_o is low or while the row is closed.
- R8: A request presented while the row is open, in the last cycle of a column access, is accepted there. If it is for the same row, the row stays open and the read result is due 6 cycles after acceptance. A request for a different row closes the row and goes through precharge: the read result is due 10 cycles after acceptance, the same as from idle.
- R9: After 8 column accesses in one row, the row closes even if the next request is for the same row. That request then takes the 10-cycle path.
- R10: busy_o is high in every cycle in which a request cannot be accepted, including the cycle right after an acceptance. A request is taken at the first clock edge at which req_valid_i is high and busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Word address, row in bits 15:8 |
| req_wdata_i | input | 4 | Write nibble |
| busy_o | output | 1 | Request cannot be taken this cycle |
| rd_valid_o | output | 1 | Read nibble valid, one-cycle pulse |
| rd_data_o | output | 4 | Read nibble |
| dram_a_o | output | 9 | Multiplexed row/column address |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| we_n_o | output | 1 | Write strobe, active low |
| dram_dq_io | inout | 4 | Memory data bus |

## Verification
A read accepted from idle, or one that needs a new row, gives its nibble on the tenth clock edge after the edge that accepted it. A read that follows in the open row gives it on the sixth edge. A scoreboard entry records the acceptance cycle and the expected latency, and the monitor checks both the nibble and the elapsed count at the half-cycle after rd_valid_o rises. The strobe spacings (3 cycles of precharge, 3 cycles from row strobe to column strobe, 4 cycles of column strobe low, 2 cycles high inside a row) are measured by run counters sampled on falling clock edges. The bench memory model drives read data and receives write data at the same falling-edge points, away from the edges at which the controller samples.

// File: rtl/dline_pkg.sv
package dline_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_RCD,
    ST_CAS,
    ST_CP
  } seq_state_e;
endpackage

// File: rtl/dline_seq.sv
module dline_seq
  import dline_pkg::*;
#(
  parameter int T_RP      = 3,
  parameter int T_RAH     = 1,
  parameter int T_RCD     = 3,
  parameter int T_CAS     = 4,
  parameter int T_CP      = 2,
  parameter int MAX_BURST = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic same_row_i,
  output logic busy_o,
  output logic accept_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic col_sel_o,
  output logic sample_o
);
  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int TMAX  = maxi(maxi(T_RP, T_RCD), maxi(T_CAS, T_CP));
  localparam int CNT_W = $clog2(TMAX + 1);
  localparam int BC_W  = $clog2(MAX_BURST + 1);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BC_W-1:0]  bc_q, bc_d;
  logic             last, full;

  assign last     = (cnt_q == '0);
  assign full     = (bc_q == BC_W'(MAX_BURST));
  assign busy_o   = !((st_q == ST_IDLE) || (st_q == ST_CAS && last));
  assign accept_o = req_valid_i && !busy_o;

  always_comb begin
    st_d  = st_q;
    cnt_d = last ? cnt_q : cnt_q - 1'b1;
    bc_d  = bc_q;
    unique case (st_q)
      ST_IDLE: if (accept_o) begin
        st_d  = ST_PRE;
        cnt_d = CNT_W'(T_RP - 1);
        bc_d  = '0;
      end
      ST_PRE: if (last) begin
        st_d  = ST_RCD;
        cnt_d = CNT_W'(T_RCD - 1);
      end
      ST_RCD: if (last) begin
        st_d  = ST_CAS;
        cnt_d = CNT_W'(T_CAS - 1);
        bc_d  = bc_q + 1'b1;
      end
      ST_CAS: if (last) begin
        if (accept_o && same_row_i && !full) begin
          st_d  = ST_CP;
          cnt_d = CNT_W'(T_CP - 1);
        end else if (accept_o) begin
          st_d  = ST_PRE;
          cnt_d = CNT_W'(T_RP - 1);
          bc_d  = '0;
        end else begin
          st_d = ST_IDLE;
          bc_d = '0;
        end
      end
      ST_CP: if (last) begin
        st_d  = ST_CAS;
        cnt_d = CNT_W'(T_CAS - 1);
        bc_d  = bc_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      bc_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      bc_q  <= bc_d;
    end
  end

  // row address for the first T_RAH cycles of the row strobe, column after
  assign ras_n_o   = !(st_q == ST_RCD || st_q == ST_CAS || st_q == ST_CP);
  assign cas_n_o   = (st_q != ST_CAS);
  assign col_sel_o = (st_q == ST_CAS) || (st_q == ST_CP) ||
                     (st_q == ST_RCD && cnt_q < CNT_W'(T_RCD - T_RAH));
  assign sample_o  = (st_q == ST_CAS) && last;

  a_r2_precharge_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |=> ras_n_o);
  a_r3_col_before_cas: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_n_o) |-> $past(col_sel_o));
  a_r9_burst_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CP) |-> (bc_q < BC_W'(MAX_BURST)));
endmodule

// File: rtl/dline_pad.sv
module dline_pad #(
  parameter int AW    = 16,
  parameter int DW    = 4,
  parameter int PIN_W = 9,
  parameter int ROW_W = 8,
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             req_we_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [DW-1:0]    req_wdata_i,
  input  logic             ras_n_i,
  input  logic             cas_n_i,
  input  logic             col_sel_i,
  input  logic             sample_i,
  input  logic [DW-1:0]    dq_i,
  output logic             same_row_o,
  output logic [PIN_W-1:0] dram_a_o,
  output logic             rd_n_o,
  output logic             we_n_o,
  output logic [DW-1:0]    dq_o,
  output logic             dq_oe_o,
  output logic             rd_valid_o,
  output logic [DW-1:0]    rd_data_o
);
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic             we_q;
  logic [ROW_W-1:0] row_w;
  logic [COL_W-1:0] col_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else if (accept_i) begin
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      we_q    <= req_we_i;
    end
  end

  assign row_w      = addr_q[AW-1 -: ROW_W];
  assign col_w      = addr_q[COL_W-1:0];
  assign same_row_o = (req_addr_i[AW-1 -: ROW_W] == row_w);
  assign dram_a_o   = col_sel_i ? PIN_W'(col_w) : PIN_W'(row_w);
  assign we_n_o     = !(!cas_n_i && we_q);
  assign rd_n_o     = !(!cas_n_i && !we_q);
  assign dq_o       = wdata_q;
  assign dq_oe_o    = we_q && col_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= sample_i && !we_q;
      if (sample_i && !we_q) rd_data_o <= dq_i;
    end
  end

  a_r5_strobe_has_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> (dq_oe_o && $past(dq_oe_o)));
  a_r7_no_drive_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (rd_n_o && !ras_n_i));
  a_r8_row_held_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_i && $past(!ras_n_i)) |-> $stable(row_w));
  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);
endmodule

// File: rtl/dline_dram_ctrl.sv
module dline_dram_ctrl #(
  parameter int AW        = 16,
  parameter int DW        = 4,
  parameter int PIN_W     = 9,
  parameter int T_RP      = 3,
  parameter int T_RAH     = 1,
  parameter int T_RCD     = 3,
  parameter int T_CAS     = 4,
  parameter int T_CP      = 2,
  parameter int MAX_BURST = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_we_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [DW-1:0]    req_wdata_i,
  output logic             busy_o,
  output logic             rd_valid_o,
  output logic [DW-1:0]    rd_data_o,
  output logic [PIN_W-1:0] dram_a_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             rd_n_o,
  output logic             we_n_o,
  inout  wire  [DW-1:0]    dram_dq_io
);
  localparam int ROW_W = AW - AW / 2;
  localparam int COL_W = AW / 2;

  logic          accept, same_row, col_sel, sample, dq_oe;
  logic [DW-1:0] dq_out, dq_in;

  dline_seq #(
    .T_RP(T_RP), .T_RAH(T_RAH), .T_RCD(T_RCD),
    .T_CAS(T_CAS), .T_CP(T_CP), .MAX_BURST(MAX_BURST)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .same_row_i (same_row),
    .busy_o     (busy_o),
    .accept_o   (accept),
    .ras_n_o    (ras_n_o),
    .cas_n_o    (cas_n_o),
    .col_sel_o  (col_sel),
    .sample_o   (sample)
  );

  dline_pad #(
    .AW(AW), .DW(DW), .PIN_W(PIN_W), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_pad (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .req_we_i   (req_we_i),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .ras_n_i    (ras_n_o),
    .cas_n_i    (cas_n_o),
    .col_sel_i  (col_sel),
    .sample_i   (sample),
    .dq_i       (dq_in),
    .same_row_o (same_row),
    .dram_a_o   (dram_a_o),
    .rd_n_o     (rd_n_o),
    .we_n_o     (we_n_o),
    .dq_o       (dq_out),
    .dq_oe_o    (dq_oe),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );

  assign dram_dq_io = dq_oe ? dq_out : 'z;
  assign dq_in      = dram_dq_io;
endmodule

// File: tb/dline_dram_ctrl_test.sv
module dline_dram_ctrl_test;
  localparam int MAXB = 8;
  localparam logic [3:0] PARK = 4'h9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        busy_o, rd_valid_o, ras_n_o, cas_n_o, rd_n_o, we_n_o;
  logic [3:0]  rd_data_o;
  logic [8:0]  dram_a_o;
  wire  [3:0]  dq;

  int vectors = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dline_dram_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .busy_o(busy_o),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .dram_a_o(dram_a_o),
    .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .rd_n_o(rd_n_o), .we_n_o(we_n_o),
    .dram_dq_io(dq)
  );

  // memory model: drives read data during the read strobe, parks the bus while the row is closed
  logic [3:0] mem [int];
  logic [3:0] shadow [int];
  logic [3:0] model_val = '0;
  logic [7:0] m_row = '0;
  assign dq = (!cas_n_o && !rd_n_o) ? model_val : (ras_n_o ? PARK : 'z);

  function automatic logic [3:0] dflt(input logic [15:0] a);
    return a[3:0] ^ a[11:8] ^ 4'h5;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // scoreboard
  logic [3:0] q_data[$];
  int         q_lat[$];
  int         q_cyc[$];
  logic [15:0] acc_addr = '0;
  logic [3:0]  acc_wdata = '0;
  logic [7:0]  b_row = '0;
  int          b_cnt = 0;

  task automatic issue(input logic we, input logic [15:0] a, input logic [3:0] d);
    int lat;
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (busy_o) @(negedge clk);
    if (!ras_n_o && a[15:8] == b_row && b_cnt < MAXB) begin
      lat = 6; b_cnt++;
    end else begin
      lat = 10; b_cnt = 1; b_row = a[15:8];
    end
    @(posedge clk);
    @(negedge clk);
    acc_addr = a; acc_wdata = d;
    check(busy_o == 1'b1, "R10 busy after accept", busy_o, 1);
    req_valid = 1'b0;
    if (we) shadow[int'(a)] = d;
    else begin
      q_data.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : dflt(a));
      q_lat.push_back(lat);
      q_cyc.push_back(cyc);
    end
  endtask

  // monitor and pin-timing checks, all at falling edges
  bit ras_prev = 1, cas_prev = 1, we_prev = 1, rv_prev = 0, first_cas = 0;
  int ras_hi = 10, cas_hi = 0, cas_lo = 0;
  logic [3:0] dq_h1 = '0, dq_h2 = '0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rd_valid_o) begin
        check(!rv_prev, "R6 single pulse", rv_prev, 0);
        if (q_data.size() == 0) check(0, "R6 unexpected valid", 1, 0);
        else begin
          logic [3:0] ed; int el, ec;
          ed = q_data.pop_front(); el = q_lat.pop_front(); ec = q_cyc.pop_front();
          check(rd_data_o == ed, "R6 read nibble", rd_data_o, ed);
          check(cyc - ec == el, "R8 read latency", cyc - ec, el);
        end
      end
      if (!ras_n_o && ras_prev) begin
        check(ras_hi >= 3, "R2 precharge", ras_hi, 3);
        check(dram_a_o == {1'b0, acc_addr[15:8]}, "R3 row address", dram_a_o, {1'b0, acc_addr[15:8]});
        m_row = dram_a_o[7:0];
        first_cas = 1; cas_hi = 0;
      end
      if (!cas_n_o && cas_prev) begin
        check(cas_hi == (first_cas ? 3 : 2), "R3 R4 strobe spacing", cas_hi, first_cas ? 3 : 2);
        check(dram_a_o == {1'b0, acc_addr[7:0]}, "R3 column address", dram_a_o, {1'b0, acc_addr[7:0]});
        if (!we_n_o) mem[int'({m_row, dram_a_o[7:0]})] = dq;
        if (!rd_n_o) begin
          check(we_n_o, "R6 no write strobe on read", we_n_o, 1);
          model_val = mem.exists(int'({m_row, dram_a_o[7:0]})) ?
                      mem[int'({m_row, dram_a_o[7:0]})] : dflt({m_row, dram_a_o[7:0]});
        end
        first_cas = 0; cas_hi = 0;
      end
      if (cas_n_o && !cas_prev) check(cas_lo == 4, "R4 strobe low width", cas_lo, 4);
      if (!we_n_o && we_prev) begin
        check(!cas_n_o && rd_n_o, "R5 strobe pairing", {cas_n_o, rd_n_o}, 1);
        check(dq == acc_wdata && dq_h1 == dq && dq_h2 == dq, "R5 write data setup", dq, acc_wdata);
      end
      if (!we_n_o) check(dq == acc_wdata, "R5 write data hold", dq, acc_wdata);
      if (we_n_o && !we_prev) check(cas_n_o, "R5 strobe ends with column", cas_n_o, 1);
      if (ras_n_o) check(dq == PARK, "R7 bus released", dq, PARK);
      ras_hi = ras_n_o ? ras_hi + 1 : 0;
      if (!ras_n_o && cas_n_o) cas_hi++;
      cas_lo = !cas_n_o ? cas_lo + 1 : 0;
      ras_prev = ras_n_o; cas_prev = cas_n_o; we_prev = we_n_o; rv_prev = rd_valid_o;
      dq_h2 = dq_h1; dq_h1 = dq;
    end
  end

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check({ras_n_o, cas_n_o, rd_n_o, we_n_o} == 4'hF, "R1 strobes in reset", {ras_n_o, cas_n_o, rd_n_o, we_n_o}, 4'hF);
    check(!busy_o && !rd_valid_o, "R1 flags in reset", {busy_o, rd_valid_o}, 0);
    check(dq == PARK, "R1 bus released in reset", dq, PARK);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({ras_n_o, cas_n_o, rd_n_o, we_n_o} == 4'hF, "R1 strobes idle", {ras_n_o, cas_n_o, rd_n_o, we_n_o}, 4'hF);
    check(!busy_o, "R10 idle not busy", busy_o, 0);

    // single write then single read from idle
    issue(1'b1, 16'h1234, 4'h5);
    repeat (12) @(negedge clk);
    issue(1'b0, 16'h1234, 4'h0);
    repeat (12) @(negedge clk);

    // open-row burst: R8, then limit R9, then row change R8
    for (int i = 0; i < 4; i++) issue(1'b1, {8'h56, 8'(i * 17)}, 4'(i + 10));
    for (int i = 0; i < 4; i++) issue(1'b0, {8'h56, 8'(i * 17)}, 4'h0);
    issue(1'b0, 16'h5600, 4'h0);
    issue(1'b0, 16'h7701, 4'h0);
    issue(1'b0, 16'h7722, 4'h0);
    repeat (14) @(negedge clk);

    // address extremes
    issue(1'b1, 16'hFFFF, 4'h9);
    issue(1'b1, 16'h0000, 4'h6);
    issue(1'b0, 16'hFFFF, 4'h0);
    issue(1'b0, 16'h0000, 4'h0);
    issue(1'b0, 16'h00FF, 4'h0);
    repeat (20) @(negedge clk);

    check(q_data.size() == 0, "R6 all reads returned", q_data.size(), 0);
    check(!busy_o && ras_n_o, "R10 returns idle", {busy_o, ras_n_o}, 1);
    finish_run();
  end
endmodule